// File: doc/BRIEF.md
# Serial PHY Management Controller

This block is the host side of the two-wire PHY management link (MDC clock, MDIO data). It can run in three ways. In frame mode the host writes one 32-bit command word. The block sends a preamble of 32 ones followed by that word, MSB first, on MDC/MDIO. For a read it releases the data line during the turnaround and data bits and captures the 16 bits the PHY returns. Completion is shown in the command register itself, so the host polls that register until the transaction is done. In bit-bang mode three one-bit host registers drive MDC, the outgoing data bit and the data-line output enable directly, and software builds each bit's edges itself. In poll mode the block reads one PHY register over and over on its own. It compares each result with the previous one and raises an interrupt when a bit the host has unmasked changes.

A PHY-select configuration bit steers the data line to one of two MDIO pins. Only that pin is ever driven; the other pin stays released. MDC is made from the system clock by a divider parameter, so one MDC half period lasts `DIV` system clocks. Outgoing data changes on the MDC falling edge and incoming data is sampled on the MDC rising edge.

Host registers, selected by `host_sel`: 0 command word, 1 bit-bang clock, 2 bit-bang data, 3 bit-bang output enable, 4 configuration, 5 poll mask, 6 poll status. `host_rdata` shows the selected register combinationally. A read strobe matters only for the poll status register.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset MDC is 0, both output enables and both data outputs are 0, `poll_irq` is 0, and the command register reads 32'h0001_0000 (idle, complete).
- R2: A host write to the command register (select 0), with bit-banging off, sends 32 ones and then the 32 written bits MSB first. MDC has a period of 2*DIV system clocks, and the data output holds steady across every MDC rising edge.
- R3: Command bit 16 reads 0 from the write until the frame has ended, and 1 afterwards. For an idle block, writing at clock edge E makes bit 16 read 1 after edge E+128*DIV+2 and not before.
- R4: A command with bits [29:28] = 2'b10 is a read. The output enable is high for the first 14 bits after the preamble and low from the turnaround bits onward. When the read completes, bits [15:0] hold the 16 bits sampled from the PHY, MSB first, and bits [31:17] keep their written value.
- R5: Configuration bit 0 selects the driven pin (0 or 1). The unselected pin's output enable and data output stay 0 at all times, and at most one output enable is high.
- R6: When configuration bit 2 is 1 (bit-bang), MDC follows bit 0 of register 1, the selected data output follows bit 0 of register 2, and the selected output enable follows bit 0 of register 3. MDC changes only after a write to register 1.
- R7: Bit 1 of register 2 reads the current level of the selected MDIO input pin.
- R8: When configuration bit 1 is 1 and bit-banging is off, the block repeatedly reads the register addressed by configuration bits [7:3] of the PHY addressed by bits [12:8]. The first result after poll mode is switched on only sets the baseline value.
- R9: Poll status bits [15:0] hold the latest polled value. Bits [31:16] collect every bit that differed from the previous poll result and whose poll mask bit (register 5) is 1. `poll_irq` is 1 while any collected bit is set, and changes in masked-off bits raise nothing.
- R10: A read strobe on the poll status register returns the current value and clears bits [31:16], so `poll_irq` is 0 in the next cycle unless a new change arrives in that same cycle.
- R11: A command write that lands while a poll frame is in flight is held. It is sent as soon as that poll frame ends, ahead of the next poll read, and it completes within two frame times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe (clears poll status) |
| host_sel | input | 3 | Host register select |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Selected register contents |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_out | output | 2 | Data output per MDIO pin |
| mdio_oe | output | 2 | Output enable per MDIO pin |
| mdio_in | input | 2 | Data input per MDIO pin |
| poll_irq | output | 1 | Poll-change interrupt |

## Verification
Two situations are the hardest to reach from the ports. The first is a host command arriving while an autonomous poll read is already on the wire. The bench switches poll mode on and then writes a command at once, so the write is certain to meet a poll frame in flight. It then checks that the PHY responder saw the command word unchanged and that completion came within two frame times. The second is the release of the data line at the turnaround of a read. The behavioural PHY counts every MDC rising edge where the enable state is wrong for the bit position, over host reads and poll reads on both pins. It also checks the returned data at the all-zero and all-one extremes.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

   typedef enum logic [2:0] {
      SEL_CMD   = 3'd0,
      SEL_BBCLK = 3'd1,
      SEL_BBDAT = 3'd2,
      SEL_BBOE  = 3'd3,
      SEL_CFG   = 3'd4,
      SEL_PMASK = 3'd5,
      SEL_PSTAT = 3'd6,
      SEL_NONE  = 3'd7
   } host_sel_e;

   localparam int          NPINS     = 2;
   localparam int          CMD_W     = 32;
   localparam int          VAL_W     = 16;
   localparam int          CFG_W     = 13;
   localparam int          DONE_BIT  = 16;
   localparam logic [1:0]  OP_RD     = 2'b10;
   localparam logic [1:0]  ST_CODE   = 2'b01;

   localparam int          CFG_PIN   = 0;
   localparam int          CFG_POLL  = 1;
   localparam int          CFG_BB    = 2;
   localparam int          CFG_REG_L = 3;
   localparam int          CFG_PHY_L = 8;

endpackage

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine import mdio_pkg::*; #(
   parameter int DIV      = 4,
   parameter int PRE_BITS = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [CMD_W-1:0]   cmd,
   input  logic               mdi,
   output logic               mdc,
   output logic               mdo,
   output logic               oe,
   output logic               busy,
   output logic               done,
   output logic [VAL_W-1:0]   rdata
);
   localparam int TOTAL   = PRE_BITS + CMD_W;
   localparam int CW      = (DIV > 2) ? $clog2(DIV) : 1;
   localparam int IW      = $clog2(TOTAL);
   localparam int REL_IDX = PRE_BITS + 14;

   logic             busy_q, mdc_q, done_q, is_rd_q;
   logic [CW-1:0]    cnt_q;
   logic [IW-1:0]    idx_q;
   logic [TOTAL-1:0] sh_q;
   logic [VAL_W-1:0] rd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         mdc_q   <= 1'b0;
         done_q  <= 1'b0;
         is_rd_q <= 1'b0;
         cnt_q   <= '0;
         idx_q   <= '0;
         sh_q    <= '0;
         rd_q    <= '0;
      end else begin
         done_q <= 1'b0;
         if (!busy_q) begin
            if (start) begin
               busy_q  <= 1'b1;
               mdc_q   <= 1'b0;
               cnt_q   <= CW'(DIV - 1);
               idx_q   <= '0;
               sh_q    <= {{PRE_BITS{1'b1}}, cmd};
               is_rd_q <= (cmd[29:28] == OP_RD);
            end
         end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
         end else begin
            cnt_q <= CW'(DIV - 1);
            if (!mdc_q) begin
               mdc_q <= 1'b1;
               rd_q  <= {rd_q[VAL_W-2:0], mdi};
            end else begin
               mdc_q <= 1'b0;
               if (idx_q == IW'(TOTAL - 1)) begin
                  busy_q <= 1'b0;
                  done_q <= 1'b1;
               end else begin
                  idx_q <= idx_q + 1'b1;
                  sh_q  <= {sh_q[TOTAL-2:0], 1'b0};
               end
            end
         end
      end
   end

   assign mdc   = mdc_q;
   assign mdo   = busy_q & sh_q[TOTAL-1];
   assign oe    = busy_q & ~(is_rd_q & (idx_q >= IW'(REL_IDX)));
   assign busy  = busy_q;
   assign done  = done_q;
   assign rdata = rd_q;
endmodule

// File: rtl/mdio_poll_unit.sv
module mdio_poll_unit import mdio_pkg::*; (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               enable,
   input  logic               res_valid,
   input  logic [VAL_W-1:0]   res,
   input  logic [VAL_W-1:0]   mask,
   input  logic               clr,
   output logic [2*VAL_W-1:0] status,
   output logic               irq,
   output logic               hit
);
   logic [VAL_W-1:0] prev_q, chg_q, diff;
   logic             base_q;

   assign diff = (res ^ prev_q) & mask;
   assign hit  = res_valid & base_q & (|diff);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         chg_q  <= '0;
         base_q <= 1'b0;
      end else begin
         if (!enable)
            base_q <= 1'b0;
         else if (res_valid)
            base_q <= 1'b1;
         if (res_valid)
            prev_q <= res;
         chg_q <= (clr ? '0 : chg_q) | (hit ? diff : '0);
      end
   end

   assign status = {chg_q, prev_q};
   assign irq    = |chg_q;
endmodule

// File: rtl/mdio_pin_steer.sv
module mdio_pin_steer import mdio_pkg::*; (
   input  logic             sel,
   input  logic             dout,
   input  logic             doe,
   output logic [NPINS-1:0] pin_out,
   output logic [NPINS-1:0] pin_oe,
   input  logic [NPINS-1:0] pin_in,
   output logic             din
);
   for (genvar i = 0; i < NPINS; i++) begin : g_pin
      assign pin_out[i] = (sel == 1'(i)) & dout;
      assign pin_oe[i]  = (sel == 1'(i)) & doe;
   end
   assign din = pin_in[sel];
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl import mdio_pkg::*; #(
   parameter int DIV      = 4,
   parameter int PRE_BITS = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic [2:0]        host_sel,
   input  logic [31:0]       host_wdata,
   output logic [31:0]       host_rdata,
   output logic              mdc,
   output logic [NPINS-1:0]  mdio_out,
   output logic [NPINS-1:0]  mdio_oe,
   input  logic [NPINS-1:0]  mdio_in,
   output logic              poll_irq
);
   if (DIV < 2) begin : g_bad_div
      $error("DIV must be at least 2");
   end
   if (PRE_BITS < 1) begin : g_bad_pre
      $error("PRE_BITS must be at least 1");
   end

   logic [CMD_W-1:0] cmd_q;
   logic             pend_q, host_act_q, owner_poll_q;
   logic             bbclk_q, bbdat_q, bboe_q;
   logic [CFG_W-1:0] cfg_q;
   logic [VAL_W-1:0] mask_q;

   logic             phy_sel, bb_mode, poll_on, poll_hit, din;
   logic             host_go, poll_go, eng_start;
   logic             eng_mdc, eng_mdo, eng_oe, eng_busy, eng_done;
   logic [VAL_W-1:0] eng_rdata;
   logic [CMD_W-1:0] eng_cmd, poll_cmd;
   logic [2*VAL_W-1:0] pstat;
   host_sel_e        sel;

   assign sel      = host_sel_e'(host_sel);
   assign phy_sel  = cfg_q[CFG_PIN];
   assign bb_mode  = cfg_q[CFG_BB];
   assign poll_on  = cfg_q[CFG_POLL] & ~bb_mode;
   assign poll_cmd = {ST_CODE, OP_RD, cfg_q[CFG_PHY_L +: 5], cfg_q[CFG_REG_L +: 5],
                      2'b11, {VAL_W{1'b1}}};

   assign host_go   = pend_q & ~eng_busy & ~bb_mode;
   assign poll_go   = ~pend_q & poll_on & ~eng_busy;
   assign eng_start = host_go | poll_go;
   assign eng_cmd   = host_go ? cmd_q : poll_cmd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q        <= 32'h0001_0000;
         pend_q       <= 1'b0;
         host_act_q   <= 1'b0;
         owner_poll_q <= 1'b0;
         bbclk_q      <= 1'b0;
         bbdat_q      <= 1'b0;
         bboe_q       <= 1'b0;
         cfg_q        <= '0;
         mask_q       <= '0;
      end else begin
         if (eng_done && !owner_poll_q) begin
            host_act_q      <= 1'b0;
            cmd_q[DONE_BIT] <= 1'b1;
            if (cmd_q[29:28] == OP_RD)
               cmd_q[VAL_W-1:0] <= eng_rdata;
         end
         if (eng_start && !eng_busy)
            owner_poll_q <= ~host_go;
         if (host_go) begin
            pend_q     <= 1'b0;
            host_act_q <= 1'b1;
         end
         if (host_wr) begin
            unique case (sel)
               SEL_CMD:   if (!pend_q && !host_act_q) begin
                             cmd_q  <= {host_wdata[31:17], 1'b0, host_wdata[15:0]};
                             pend_q <= 1'b1;
                          end
               SEL_BBCLK: bbclk_q <= host_wdata[0];
               SEL_BBDAT: bbdat_q <= host_wdata[0];
               SEL_BBOE:  bboe_q  <= host_wdata[0];
               SEL_CFG:   cfg_q   <= host_wdata[CFG_W-1:0];
               SEL_PMASK: mask_q  <= host_wdata[VAL_W-1:0];
               default: ;
            endcase
         end
      end
   end

   mdio_frame_engine #(.DIV(DIV), .PRE_BITS(PRE_BITS)) u_eng (
      .clk(clk), .rst_n(rst_n), .start(eng_start), .cmd(eng_cmd), .mdi(din),
      .mdc(eng_mdc), .mdo(eng_mdo), .oe(eng_oe), .busy(eng_busy),
      .done(eng_done), .rdata(eng_rdata)
   );

   mdio_poll_unit u_poll (
      .clk(clk), .rst_n(rst_n), .enable(poll_on),
      .res_valid(eng_done & owner_poll_q), .res(eng_rdata), .mask(mask_q),
      .clr(host_rd & (sel == SEL_PSTAT)), .status(pstat), .irq(poll_irq),
      .hit(poll_hit)
   );

   mdio_pin_steer u_pins (
      .sel(phy_sel),
      .dout(bb_mode ? bbdat_q : eng_mdo),
      .doe(bb_mode ? bboe_q : eng_oe),
      .pin_out(mdio_out), .pin_oe(mdio_oe), .pin_in(mdio_in), .din(din)
   );

   assign mdc = bb_mode ? bbclk_q : eng_mdc;

   always_comb begin
      unique case (sel)
         SEL_CMD:   host_rdata = cmd_q;
         SEL_BBCLK: host_rdata = {31'd0, bbclk_q};
         SEL_BBDAT: host_rdata = {30'd0, din, bbdat_q};
         SEL_BBOE:  host_rdata = {31'd0, bboe_q};
         SEL_CFG:   host_rdata = {{(32-CFG_W){1'b0}}, cfg_q};
         SEL_PMASK: host_rdata = {16'd0, mask_q};
         SEL_PSTAT: host_rdata = pstat;
         default:   host_rdata = '0;
      endcase
   end
endmodule

// File: rtl/mdio_mgmt_checker.sv
module mdio_mgmt_checker import mdio_pkg::*; (
   input logic             clk,
   input logic             rst_n,
   input logic             mdc,
   input logic [NPINS-1:0] mdio_out,
   input logic [NPINS-1:0] mdio_oe,
   input logic             host_wr,
   input logic             host_rd,
   input logic [2:0]       host_sel,
   input logic             poll_irq,
   input logic             phy_sel,
   input logic             bb_mode,
   input logic             poll_hit
);
   // R5: never more than one driven pin
   a_r5_single_driver: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(mdio_oe));

   // R5: unselected pin fully released
   a_r5_unselected_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (mdio_oe[!phy_sel] == 1'b0) && (mdio_out[!phy_sel] == 1'b0));

   // R2: data steady across each MDC rising edge in frame mode
   a_r2_stable_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (!bb_mode && $past(!bb_mode) && $rose(mdc)) |-> $stable(mdio_out));

   // R6: in bit-bang mode MDC moves only after a clock-register write
   a_r6_bb_clock_source: assert property (@(posedge clk) disable iff (!rst_n)
      (bb_mode && $past(bb_mode) && !$stable(mdc)) |->
         $past(host_wr && (host_sel == SEL_BBCLK)));

   // R10: status read drops the interrupt when no new change arrives
   a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && (host_sel == SEL_PSTAT) && !poll_hit) |=> !poll_irq);
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_checker u_chk (
   .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe),
   .host_wr(host_wr), .host_rd(host_rd), .host_sel(host_sel), .poll_irq(poll_irq),
   .phy_sel(phy_sel), .bb_mode(bb_mode), .poll_hit(poll_hit)
);

// File: tb/sim_mdio_mgmt_ctrl.sv
`timescale 1ns/1ps
module sim_mdio_mgmt_ctrl;
   localparam int DIV   = 4;
   localparam int FRAME = 128 * DIV;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        host_wr, host_rd;
   logic [2:0]  host_sel;
   logic [31:0] host_wdata;
   logic [31:0] host_rdata;
   logic        mdc, poll_irq;
   logic [1:0]  mdio_out, mdio_oe, mdio_in, in_model, bb_vals;
   logic        bb_force;

   int checks = 0, errors = 0, cyc = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc++;

   assign mdio_in = bb_force ? bb_vals : in_model;

   mdio_mgmt_ctrl #(.DIV(DIV)) u0 (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
      .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in),
      .poll_irq(poll_irq)
   );

   // ---------------- behavioural PHY responder ----------------
   logic [15:0] phy_regs [32];
   int          model_pin = 0;
   bit          model_on  = 1;
   int          ones = 0, k = 0, frame_cnt = 0;
   int          early_oe_bad = 0, rd_oe_bad = 0, other_bad = 0;
   int          per_last = 0, rise_cyc = 0;
   bit          in_frame = 0, rd_op = 0;
   logic [31:0] cap = '0, last_write = '0;
   logic [15:0] rd_val = '0;
   logic        b;

   initial in_model = 2'b11;

   always @(mdc) begin
      if (model_on) begin
         if (mdc === 1'b1) begin
            per_last = cyc - rise_cyc;
            rise_cyc = cyc;
            if (mdio_oe[1-model_pin]) other_bad++;
            b = mdio_oe[model_pin] ? mdio_out[model_pin] : 1'b1;
            if (!in_frame) begin
               if (b) ones++;
               else begin
                  if (ones >= 32) begin in_frame = 1; k = 1; cap = '0; end
                  ones = 0;
               end
            end else begin
               if (k < 14 && !mdio_oe[model_pin]) early_oe_bad++;
               if (k >= 14 && rd_op && mdio_oe[model_pin]) rd_oe_bad++;
               cap = {cap[30:0], b};
               k++;
               if (k == 14) begin
                  rd_op  = (cap[11:10] == 2'b10);
                  rd_val = phy_regs[cap[4:0]];
               end
               if (k == 32) begin
                  if (!rd_op) last_write = cap;
                  frame_cnt++;
                  in_frame = 0;
                  rd_op = 0;
                  in_model = 2'b11;
               end
            end
         end else if (in_frame && rd_op) begin
            if (k == 15) in_model[model_pin] = 1'b0;
            else if (k >= 16 && k <= 31) in_model[model_pin] = rd_val[31-k];
         end
      end
   end

   // ---------------- helpers ----------------
   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic host_write(input logic [2:0] s, input logic [31:0] d);
      @(negedge clk);
      host_wr = 1'b1; host_sel = s; host_wdata = d;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic peek(input logic [2:0] s, output logic [31:0] v);
      host_sel = s;
      #1 v = host_rdata;
   endtask

   task automatic host_read(input logic [2:0] s, output logic [31:0] v);
      @(negedge clk);
      host_rd = 1'b1; host_sel = s;
      #1 v = host_rdata;
      @(negedge clk);
      host_rd = 1'b0;
   endtask

   task automatic wait_done(input int lim, output int n);
      logic [31:0] v;
      n = 0;
      peek(3'd0, v);
      while (!v[16] && n < lim) begin
         @(negedge clk);
         n++;
         peek(3'd0, v);
      end
   endtask

   function automatic logic [31:0] wr_word(input logic [4:0] phy, input logic [4:0] rg,
                                           input logic [15:0] d);
      return {2'b01, 2'b01, phy, rg, 2'b10, d};
   endfunction

   function automatic logic [31:0] rd_word(input logic [4:0] phy, input logic [4:0] rg);
      return {2'b01, 2'b10, phy, rg, 2'b00, 16'h0000};
   endfunction

   function automatic logic [12:0] cfg_word(input logic [4:0] phy, input logic [4:0] rg,
                                            input bit bb, input bit poll, input bit pin);
      return {phy, rg, bb, poll, pin};
   endfunction

   // ---------------- watchdog ----------------
   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=<190000 cycles", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   // ---------------- main sequence ----------------
   initial begin
      logic [31:0] v, w;
      logic [15:0] val;
      logic [4:0]  phy, rg;
      int          n, oe_e0, oe_r0;
      void'($urandom(32'd1741));
      rst_n = 1'b0; host_wr = 1'b0; host_rd = 1'b0; host_sel = 3'd7; host_wdata = '0;
      bb_force = 1'b0; bb_vals = 2'b11;
      for (int i = 0; i < 32; i++) phy_regs[i] = 16'($urandom);
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 mdc", {31'd0, mdc}, 32'd0);
      chk("R1 oe", {30'd0, mdio_oe}, 32'd0);
      chk("R1 out", {30'd0, mdio_out}, 32'd0);
      chk("R1 irq", {31'd0, poll_irq}, 32'd0);
      peek(3'd0, v);
      chk("R1 cmd reg", v, 32'h0001_0000);

      // R2/R3 first write frame with exact completion timing
      host_write(3'd4, 32'(cfg_word(5'd0, 5'd0, 0, 0, 0)));
      model_pin = 0;
      w = wr_word(5'd3, 5'd17, 16'hC3A5);
      host_write(3'd0, w);
      repeat (FRAME + 1) @(negedge clk);
      peek(3'd0, v);
      chk("R3 busy before end", {31'd0, v[16]}, 32'd0);
      @(negedge clk);
      peek(3'd0, v);
      chk("R3 done after end", {31'd0, v[16]}, 32'd1);
      chk("R2 frame bits", last_write, w);
      chk("R2 mdc period", 32'(per_last), 32'(2 * DIV));

      // R2/R5 random writes on both pins
      for (int t = 0; t < 4; t++) begin
         model_pin = t % 2;
         host_write(3'd4, 32'(cfg_word(5'd0, 5'd0, 0, 0, model_pin[0])));
         w = wr_word(5'($urandom), 5'($urandom), 16'($urandom));
         host_write(3'd0, w);
         wait_done(FRAME + 20, n);
         chk("R2 random write frame", last_write, w);
         peek(3'd0, v);
         chk("R3 done flag", {31'd0, v[16]}, 32'd1);
      end

      // R4 reads, directed extremes then random
      oe_e0 = early_oe_bad; oe_r0 = rd_oe_bad;
      for (int t = 0; t < 6; t++) begin
         model_pin = (t >> 1) % 2;
         host_write(3'd4, 32'(cfg_word(5'd0, 5'd0, 0, 0, model_pin[0])));
         phy = 5'($urandom); rg = 5'($urandom);
         val = (t == 0) ? 16'h0000 : (t == 1) ? 16'hFFFF : (t == 2) ? 16'h8001 : 16'($urandom);
         phy_regs[rg] = val;
         w = rd_word(phy, rg);
         host_write(3'd0, w);
         @(negedge clk);
         peek(3'd0, v);
         chk("R3 busy during read", {31'd0, v[16]}, 32'd0);
         wait_done(FRAME + 20, n);
         peek(3'd0, v);
         chk("R4 read result", v, {w[31:17], 1'b1, val});
      end
      chk("R4 oe high before turnaround", 32'(early_oe_bad - oe_e0), 32'd0);
      chk("R4 oe low in read data", 32'(rd_oe_bad - oe_r0), 32'd0);
      chk("R5 unselected pin idle", 32'(other_bad), 32'd0);

      // R8 poll baseline
      model_pin = 0;
      phy_regs[3] = 16'h1234;
      host_write(3'd5, 32'h0000_00FF);
      host_write(3'd4, 32'(cfg_word(5'd5, 5'd3, 0, 1, 0)));
      repeat (3 * FRAME) @(negedge clk);
      peek(3'd6, v);
      chk("R8 baseline no irq", {31'd0, poll_irq}, 32'd0);
      chk("R8 baseline status", v, 32'h0000_1234);

      // R9 masked change raises irq
      phy_regs[3] = 16'h1335;
      repeat (3 * FRAME) @(negedge clk);
      peek(3'd6, v);
      chk("R9 status after change", v, 32'h0001_1335);
      chk("R9 irq set", {31'd0, poll_irq}, 32'd1);

      // R10 read clears
      host_read(3'd6, v);
      chk("R10 read returns value", v, 32'h0001_1335);
      peek(3'd6, v);
      chk("R10 cleared upper", v, 32'h0000_1335);
      chk("R10 irq cleared", {31'd0, poll_irq}, 32'd0);

      // R9 change in masked-off bit only
      phy_regs[3] = 16'h0335;
      repeat (3 * FRAME) @(negedge clk);
      peek(3'd6, v);
      chk("R9 masked-off change", v, 32'h0000_0335);
      chk("R9 masked-off irq", {31'd0, poll_irq}, 32'd0);

      // R11 host command while a poll frame is in flight
      w = wr_word(5'd9, 5'd7, 16'hA5C3);
      host_write(3'd0, w);
      wait_done(2 * FRAME + 8, n);
      peek(3'd0, v);
      chk("R11 command completes during poll", {31'd0, v[16]}, 32'd1);
      chk("R11 command frame intact", last_write, w);
      phy_regs[3] = 16'h0336;
      repeat (3 * FRAME) @(negedge clk);
      peek(3'd6, v);
      chk("R11 polling resumes", v, 32'h0003_0336);
      host_write(3'd4, 32'(cfg_word(5'd5, 5'd3, 0, 0, 0)));
      repeat (FRAME + 10) @(negedge clk);

      // R6/R7 bit-bang on pin 1
      model_on = 0;
      host_write(3'd4, 32'(cfg_word(5'd0, 5'd0, 1, 0, 1)));
      host_write(3'd1, 32'd1);
      @(negedge clk);
      chk("R6 mdc rises on write", {31'd0, mdc}, 32'd1);
      repeat (5) @(negedge clk);
      chk("R6 mdc holds", {31'd0, mdc}, 32'd1);
      host_write(3'd1, 32'd0);
      chk("R6 mdc falls on write", {31'd0, mdc}, 32'd0);
      for (int t = 0; t < 8; t++) begin
         logic c, d, e;
         c = 1'($urandom); d = 1'($urandom); e = 1'($urandom);
         host_write(3'd1, {31'd0, c});
         host_write(3'd2, {31'd0, d});
         host_write(3'd3, {31'd0, e});
         chk("R6 bb mdc", {31'd0, mdc}, {31'd0, c});
         chk("R6 bb data pin1", {30'd0, mdio_out}, {30'd0, d, 1'b0});
         chk("R5 bb oe pin1 only", {30'd0, mdio_oe}, {30'd0, e, 1'b0});
      end
      bb_force = 1'b1;
      bb_vals = 2'b01;
      @(negedge clk);
      peek(3'd2, v);
      chk("R7 bb input low", {31'd0, v[1]}, 32'd0);
      bb_vals = 2'b10;
      @(negedge clk);
      peek(3'd2, v);
      chk("R7 bb input high", {31'd0, v[1]}, 32'd1);

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule